// File: doc/BRIEF.md
# Watchdog Timer with Clear Code

This block is a watchdog for a small microcontroller. It starts counting when reset is released, with no setup from software. A free-running prescaler divides the clock and emits a tick once every quarter of the chosen detection time. A two-bit stage counter counts those ticks and overflows on the fourth one. The overflow is the timeout. Depending on a mode bit, the timeout raises either a one-cycle reset request or a one-cycle interrupt.

Software services the watchdog through a byte-wide write port that has two addresses. The control address holds the mode bit, the detection-time select and an enable bit. At the service address, the key value 0x4E restarts the stage counter. The key leaves the prescaler untouched, so the divider phase is not reset. As a result, the time from a service write to a timeout lies somewhere between three quarters of the nominal detection time and the full time. Software must therefore service the watchdog more often than every three quarters of the detection time.

The block has three low-power inputs: stop (including its warm-up), idle and sleep. While any of them is high, the prescaler and the stage counter are frozen. When the input drops, counting continues from the held values.

The controller is a four-state machine:
- `WD_RUN`: counting.
- `WD_HOLD`: frozen by a low-power input or by the enable bit being clear.
- `WD_FIRE_RST`: the one-cycle reset-request pulse.
- `WD_FIRE_IRQ`: the one-cycle interrupt pulse.

The state transitions are:
- From `WD_RUN` or `WD_HOLD`, an overflow goes to the fire state that the mode bit selects.
- `WD_RUN` goes to `WD_HOLD` while a freeze condition is present.
- `WD_HOLD` returns to `WD_RUN` when the freeze condition ends.
- Each fire state lasts one cycle. It then goes to `WD_HOLD` or `WD_RUN`, depending on the freeze condition.

Top module: `wdog_timer`

## Requirements
- R1: After reset, no pulse is output. The control state is enable = 1, select = 3 and mode = reset request. Counting starts at once: with no writes, the first reset-request pulse appears in the cycle after clock edge 4·Q(3) counted from reset release.
- R2: A write with wr_addr = 0 loads the control byte: bit 0 is the mode (1 = reset request, 0 = interrupt), bits 2:1 are the select s, and bit 3 is the enable. The quarter period is Q(s) = 2^(BASE_LOG2+s) clock cycles, and the detection time is 4·Q(s).
- R3: Writing 0x4E with wr_addr = 1 clears the stage counter, and the prescaler keeps its phase. No pulse appears in the cycle after a clear.
- R4: Any other value written with wr_addr = 1 has no effect on timing.
- R5: The overflow edge comes d + 3·Q edges after the clear edge, where d (1 to Q) is the distance from the clear edge to the next tick. A clear on the same edge as a tick wins, giving d = Q. The minimum 3·Q+1 occurs when the clear lands one edge before a tick; the maximum 4·Q occurs when the clear lands on a tick edge.
- R6: The pulse appears in the cycle after the overflow edge. It goes on rst_req when mode = 1 and on wdt_irq when mode = 0. It lasts one cycle, and the two outputs are never high together.
- R7: After an overflow the stage counter restarts from zero, so with no clear the next pulse follows exactly 4·Q cycles later.
- R8: While stop_mode, idle_mode or sleep_mode is high at a clock edge, the prescaler and the stage counter hold. Each such edge delays the timeout by exactly one cycle, and no pulse is raised.
- R9: With the enable bit clear, the counter and prescaler freeze in the same way as in R8, and counting resumes when the bit is set again.
- R10: Service writes spaced by no more than 3·Q edges never let a pulse out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control byte, 1 = service key |
| wr_data | input | 8 | Write data |
| stop_mode | input | 1 | Stop mode or its warm-up is active |
| idle_mode | input | 1 | Idle mode is active |
| sleep_mode | input | 1 | Sleep mode is active |
| rst_req | output | 1 | One-cycle reset request on timeout |
| wdt_irq | output | 1 | One-cycle interrupt on timeout |

## Verification
A wrong prescaler phase moves every timeout by up to one quarter period. This shows at the first pulse after a phase-aligned service write, which lands one cycle early or up to Q cycles late. A stage counter that loses or gains a count makes a pulse appear a whole quarter early or late, or go missing, within at most 4·Q cycles. A mode or state fault shows on the very first timeout, either as the wrong output line or as a pulse longer than one cycle. A freeze that fails to hold shows as a timeout that is not delayed by the length of the pause.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned SEL_W   = 2;
    localparam int unsigned NUM_SEL = 1 << SEL_W;
    localparam int unsigned STAGE_W = 2;

    localparam logic [DATA_W-1:0] SERVICE_KEY = 8'h4E;

    // write port address decode
    localparam logic ADDR_CTRL    = 1'b0;
    localparam logic ADDR_SERVICE = 1'b1;

    // control byte field positions
    localparam int unsigned BIT_MODE   = 0;
    localparam int unsigned BIT_SEL_LO = 1;
    localparam int unsigned BIT_ENABLE = 3;

    typedef enum logic [1:0] {
        WD_RUN      = 2'd0,
        WD_HOLD     = 2'd1,
        WD_FIRE_RST = 2'd2,
        WD_FIRE_IRQ = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic             enable;
        logic [SEL_W-1:0] sel;
        logic             to_reset;
    } wd_ctrl_t;

    localparam wd_ctrl_t CTRL_AT_RESET = '{enable: 1'b1, sel: 2'b11, to_reset: 1'b1};

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wd_ctrl_t          ctrl,
    output logic              service_hit
);

    wd_ctrl_t ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_AT_RESET;
        end else if (wr_en && (wr_addr == ADDR_CTRL)) begin
            ctrl_q.enable   <= wr_data[BIT_ENABLE];
            ctrl_q.sel      <= wr_data[BIT_SEL_LO +: SEL_W];
            ctrl_q.to_reset <= wr_data[BIT_MODE];
        end
    end

    // only the exact key at the service address restarts the stages
    always_comb begin
        service_hit = wr_en && (wr_addr == ADDR_SERVICE) && (wr_data == SERVICE_KEY);
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int unsigned DIV_W = BASE_LOG2 + NUM_SEL - 1;

    logic [DIV_W-1:0]   div_q;
    logic [NUM_SEL-1:0] tap;

    // free-running divider; the service key never touches it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // one tap per select code, each twice the span of the previous one
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
        assign tap[g] = &div_q[BASE_LOG2+g-1:0];
    end

    always_comb begin
        tick = run && tap[sel];
    end

endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
    import wdog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               tick,
    output logic               overflow,
    output logic [STAGE_W-1:0] cnt
);

    logic [STAGE_W-1:0] cnt_q;

    // a restart on a tick edge wins and swallows that tick
    always_comb begin
        overflow = tick && !restart && (&cnt_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + STAGE_W'(1);
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       stop_mode,
    input  logic       idle_mode,
    input  logic       sleep_mode,
    output logic       rst_req,
    output logic       wdt_irq
);

    wd_ctrl_t           ctrl;
    logic               service_hit;
    logic               freeze;
    logic               run;
    logic               tick;
    logic               overflow;
    logic [STAGE_W-1:0] stage_cnt;
    wd_state_e          state_q;
    wd_state_e          state_d;

    always_comb begin
        freeze = stop_mode || idle_mode || sleep_mode || !ctrl.enable;
        run    = !freeze;
    end

    wdog_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ctrl        (ctrl),
        .service_hit (service_hit)
    );

    wdog_prescaler #(.BASE_LOG2(BASE_LOG2)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (ctrl.sel),
        .tick  (tick)
    );

    wdog_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (service_hit),
        .tick     (tick),
        .overflow (overflow),
        .cnt      (stage_cnt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_RUN: begin
                if (overflow) begin
                    state_d = ctrl.to_reset ? WD_FIRE_RST : WD_FIRE_IRQ;
                end else if (freeze) begin
                    state_d = WD_HOLD;
                end
            end
            WD_HOLD: begin
                if (overflow) begin
                    state_d = ctrl.to_reset ? WD_FIRE_RST : WD_FIRE_IRQ;
                end else if (!freeze) begin
                    state_d = WD_RUN;
                end
            end
            WD_FIRE_RST, WD_FIRE_IRQ: begin
                state_d = freeze ? WD_HOLD : WD_RUN;
            end
        endcase
    end

    // outputs
    always_comb begin
        rst_req = 1'b0;
        wdt_irq = 1'b0;
        unique case (state_q)
            WD_FIRE_RST: rst_req = 1'b1;
            WD_FIRE_IRQ: wdt_irq = 1'b1;
            WD_RUN, WD_HOLD: begin
                rst_req = 1'b0;
                wdt_irq = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               wr_addr,
    input logic [7:0]         wr_data,
    input logic               stop_mode,
    input logic               idle_mode,
    input logic               sleep_mode,
    input logic               rst_req,
    input logic               wdt_irq,
    input logic [STAGE_W-1:0] stage_cnt
);

    logic key_wr;
    logic low_power;

    always_comb begin
        key_wr    = wr_en && wr_addr && (wr_data == 8'h4E);
        low_power = stop_mode || idle_mode || sleep_mode;
    end

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wdt_irq)); // R6

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq |=> !wdt_irq); // R6

    AST_KEY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> !(rst_req || wdt_irq)); // R3

    AST_KEY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (stage_cnt == '0)); // R3

    AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && !key_wr) |=> $stable(stage_cnt)); // R8

    AST_LP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |=> !(rst_req || wdt_irq)); // R8

endmodule

bind wdog_timer wdog_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .stop_mode  (stop_mode),
    .idle_mode  (idle_mode),
    .sleep_mode (sleep_mode),
    .rst_req    (rst_req),
    .wdt_irq    (wdt_irq),
    .stage_cnt  (stage_cnt)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stop_mode = 1'b0;
    logic       idle_mode = 1'b0;
    logic       sleep_mode = 1'b0;
    logic       rst_req;
    logic       wdt_irq;

    int n_chk = 0;
    int n_bad = 0;
    int pulse_total = 0;
    bit done = 1'b0;

    wdog_timer #(.BASE_LOG2(BASE)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .stop_mode  (stop_mode),
        .idle_mode  (idle_mode),
        .sleep_mode (sleep_mode),
        .rst_req    (rst_req),
        .wdt_irq    (wdt_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int unsigned quarter(input logic [1:0] s);
        return 32'd1 << (BASE + s);
    endfunction

    // requirement-level reference model
    logic        m_en, m_mode, m_rst, m_irq;
    logic [1:0]  m_sel, m_cnt;
    int unsigned m_div;
    logic        m_run, m_tick, m_key, m_ovf;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= 1'b1; m_sel <= 2'd3; m_mode <= 1'b1;
            m_div <= 0; m_cnt <= 2'd0; m_rst <= 1'b0; m_irq <= 1'b0;
        end else begin
            m_run  = m_en && !(stop_mode || idle_mode || sleep_mode);
            m_tick = m_run && ((m_div % quarter(m_sel)) == quarter(m_sel) - 1);
            m_key  = wr_en && wr_addr && (wr_data == 8'h4E);
            m_ovf  = m_tick && !m_key && (m_cnt == 2'd3);
            m_rst <= m_ovf && m_mode;
            m_irq <= m_ovf && !m_mode;
            m_cnt <= m_key ? 2'd0 : (m_tick ? m_cnt + 2'd1 : m_cnt);
            m_div <= m_run ? (m_div + 1) % (32'd1 << (BASE + 3)) : m_div;
            if (wr_en && !wr_addr) begin
                m_en <= wr_data[3]; m_sel <= wr_data[2:1]; m_mode <= wr_data[0];
            end
        end
    end

    // cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (rst_req !== m_rst || wdt_irq !== m_irq) begin
                n_bad++;
                $display("FAIL R6 pulse lines rst_req=%b wdt_irq=%b expected %b %b",
                         rst_req, wdt_irq, m_rst, m_irq);
            end
            if (rst_req || wdt_irq) pulse_total++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic align(input int unsigned off);
        while ((m_div % quarter(m_sel)) != off) @(negedge clk);
    endtask

    // kind: 0 none, 1 stop, 2 idle, 3 sleep, 4 enable off, 5 wrong key
    task automatic measure(input int kind, input int at, input int len, input logic [7:0] cb,
                           output int lat, output bit was_rst);
        lat = 0;
        was_rst = 1'b0;
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h4E;
        while (lat < 5000) begin
            @(negedge clk);
            lat++;
            wr_en = 1'b0;
            if (rst_req || wdt_irq) begin
                was_rst = rst_req;
                break;
            end
            if (kind >= 1 && kind <= 3 && (lat == at || lat == at + len)) begin
                if (kind == 1) stop_mode  = (lat == at);
                if (kind == 2) idle_mode  = (lat == at);
                if (kind == 3) sleep_mode = (lat == at);
            end
            if (kind == 4 && lat == at) begin
                wr_en = 1'b1; wr_addr = 1'b0; wr_data = cb & 8'hF7;
            end
            if (kind == 4 && lat == at + len) begin
                wr_en = 1'b1; wr_addr = 1'b0; wr_data = cb;
            end
            if (kind == 5 && lat == at) begin
                wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'hB1;
            end
        end
    endtask

    task automatic report();
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        int lat;
        int q;
        bit was_rst;
        int base_cnt;
        void'($urandom(32'd5813));

        repeat (4) @(negedge clk);
        chk(rst_req == 1'b0 && wdt_irq == 1'b0, "R1 outputs in reset", {rst_req, wdt_irq}, 0);
        rst_n = 1'b1;

        // R1: counting starts on its own
        lat = 0;
        while (!(rst_req || wdt_irq) && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 4 * quarter(2'd3), "R1 first timeout cycle", lat, 4 * quarter(2'd3));
        chk(rst_req == 1'b1, "R1 R6 default mode is reset request", rst_req, 1);

        // R7: self restart after overflow
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!(rst_req || wdt_irq) && lat < 5000);
        chk(lat == 4 * quarter(2'd3), "R7 next timeout without service", lat, 4 * quarter(2'd3));

        // R2 R5 R6: interrupt mode, select 0
        wr(1'b0, 8'h08);
        wr(1'b1, 8'h4E);
        q = quarter(2'd0);
        align(q - 2);
        measure(0, 0, 0, 8'h08, lat, was_rst);
        chk(lat == 3 * q + 2, "R5 minimum after key one edge before tick", lat, 3 * q + 2);
        chk(was_rst == 1'b0 && wdt_irq == 1'b1, "R6 interrupt mode pulse line", wdt_irq, 1);
        @(negedge clk);
        chk(wdt_irq == 1'b0, "R6 interrupt lasts one cycle", wdt_irq, 0);
        wr(1'b1, 8'h4E);
        align(q - 1);
        measure(0, 0, 0, 8'h08, lat, was_rst);
        chk(lat == 4 * q + 1, "R5 maximum after key on tick edge", lat, 4 * q + 1);

        // R2 R4: select 2, reset mode, wrong key ignored
        wr(1'b0, 8'h0D);
        wr(1'b1, 8'h4E);
        q = quarter(2'd2);
        align(q - 1);
        measure(5, 20, 0, 8'h0D, lat, was_rst);
        chk(lat == 4 * q + 1, "R2 R4 wrong key leaves timing", lat, 4 * q + 1);
        chk(was_rst == 1'b1, "R6 reset mode pulse line", was_rst, 1);

        // R8: each low-power input freezes the count
        for (int k = 1; k <= 3; k++) begin
            wr(1'b1, 8'h4E);
            align(q - 1);
            measure(k, 40, 37, 8'h0D, lat, was_rst);
            chk(lat == 4 * q + 1 + 37, "R8 pause extends timeout", lat, 4 * q + 1 + 37);
        end

        // R9: enable bit clear freezes the count
        wr(1'b1, 8'h4E);
        align(q - 1);
        measure(4, 40, 23, 8'h0D, lat, was_rst);
        chk(lat == 4 * q + 1 + 23, "R9 disable extends timeout", lat, 4 * q + 1 + 23);

        // R10: regular service, random spacing up to 3Q edges
        wr(1'b0, 8'h0B);
        wr(1'b1, 8'h4E);
        q = quarter(2'd1);
        base_cnt = pulse_total;
        for (int i = 0; i < 40; i++) begin
            int gap;
            gap = $urandom_range(3 * q, q);
            repeat (gap - 1) @(negedge clk);
            wr(1'b1, 8'h4E);
        end
        chk(pulse_total == base_cnt, "R10 serviced watchdog stays silent", pulse_total - base_cnt, 0);

        // random mix against the model (R3 R4 R8 R9)
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(99, 0);
            wr_en = 1'b0;
            if (r < 2) begin
                wr_en = 1'b1; wr_addr = 1'b0;
                wr_data = {4'b0000, ($urandom_range(9, 0) != 0), 1'b0,
                           1'($urandom_range(1, 0)), 1'($urandom_range(1, 0))};
            end else if (r < 5) begin
                wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h4E;
            end else if (r < 7) begin
                wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'($urandom_range(255, 0)) ^ 8'h01;
            end
            if ($urandom_range(49, 0) == 0) stop_mode  = ~stop_mode;
            if ($urandom_range(49, 0) == 0) idle_mode  = ~idle_mode;
            if ($urandom_range(49, 0) == 0) sleep_mode = ~sleep_mode;
            if ($urandom_range(3, 0) != 0) begin
                stop_mode = 1'b0; idle_mode = (idle_mode && r < 50); sleep_mode = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk(pulse_total > base_cnt, "R3 R8 random phase produced timeouts", pulse_total - base_cnt, 1);

        report();
    end

endmodule